// File: doc/BRIEF.md
# Neighbourhood Motion Vector Smoother

This block cleans outliers out of a small field of block motion vectors. For each block it weighs nine candidate vectors: the block's own vector and the vectors of the eight blocks around it. Each candidate gets an energy score. The score is an externally computed matching cost for that candidate plus a smoothness penalty: a fixed weight times the summed vector distance from the candidate to the block's neighbours. The candidate with the lowest score replaces the block's vector. The block walks the field in raster order and repeats the whole sweep a fixed number of times. Each result is written back at once, so blocks later in the same sweep already see the new value.

The vector field lives in registers inside the block. Before a run, software-side logic writes the field one entry at a time through a load port and then pulses start. During a run the block shows the index of the block it is working on. The cost source must present that block's nine candidate costs on the cost bus in the same cycle. The block handles one block per clock and reports every write-back on an update port. When the last sweep ends it pulses done, and the refined field can then be read back through a combinational read port.

Top module: `mvr_icm_refine`

## Requirements
- R1: After reset, busy, done and upd_valid are 0, and every field entry reads back as the zero vector.
- R2: While idle, ld_en writes (ld_mvx, ld_mvy) into entry ld_idx. rd_mvx/rd_mvy show entry rd_idx combinationally.
- R3: A start pulse seen while idle makes busy 1 on the next cycle. The block then presents cur_blk = 0,1,…,N-1 one per cycle, for NUM_PASS passes (default 3). done is a one-cycle pulse in the cycle after the last update, with busy already 0.
- R4: Candidate slot k (0..8) is the block at row offset k/3-1 and column offset k%3-1, so slot 4 is the block itself. Slots that fall outside the field are excluded from the choice.
- R5: The energy of a candidate is its cost plus WEIGHT (default 48) times the sum, over in-frame neighbour slots other than slot 4, of |dx|+|dy| between the candidate and that neighbour.
- R6: The selected vector is a candidate of minimum energy. upd_valid pulses for one cycle after each block, with upd_idx, upd_sel (the chosen slot) and the chosen vector.
- R7: On an energy tie, slot 4 wins if it is among the minima. Otherwise the lowest-numbered in-frame slot among the minima wins.
- R8: Updates land in place: a later block in the same sweep uses the new value. After done, the field holds the final vectors.
- R9: Energies do not overflow for any 16-bit cost and any vector components, including -128 and 127 with the defaults.
- R10: ld_en and start are ignored while busy. The field and the sweep sequence are unchanged by them.
- R11: The cost for slot k occupies cost_bus[k*CW +: CW] and is sampled in the cycle where cur_blk names the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Write one field entry (idle only) |
| ld_idx | input | IW | Entry to write |
| ld_mvx | input | VW | Horizontal component to write (signed) |
| ld_mvy | input | VW | Vertical component to write (signed) |
| start | input | 1 | Begin the sweeps |
| cost_bus | input | 9*CW | Matching costs of the nine candidates of cur_blk |
| cur_blk | output | IW | Block being refined this cycle |
| busy | output | 1 | Sweeps in progress |
| done | output | 1 | One-cycle pulse after the last update |
| upd_valid | output | 1 | An update was written last edge |
| upd_idx | output | IW | Updated entry |
| upd_sel | output | 4 | Winning candidate slot |
| upd_mvx | output | VW | Written horizontal component |
| upd_mvy | output | VW | Written vertical component |
| rd_idx | input | IW | Entry to read |
| rd_mvx | output | VW | Horizontal component of entry rd_idx |
| rd_mvy | output | VW | Vertical component of entry rd_idx |

## Verification
With zero costs on a noisy field, only the smoothness term decides the result. This shows whether distances, edge exclusion and in-place propagation are right. Random costs on a random field make cost and penalty compete, which exposes errors in the weight or the slot order of the cost bus. A flat field with a penalised own slot separates the two tie rules: the own slot wins with uniform costs, and the lowest index wins otherwise. Saturated costs on a checkerboard of extreme vectors test the accumulator range. A load and a start issued mid-run must leave both the update stream and the final field unchanged.

// File: rtl/mvr_pkg.sv
// Shared constants and types for the motion vector smoother.
// Assumes a 3x3 candidate window with the block itself in the centre slot.
package mvr_pkg;
    localparam int NCAND     = 9;
    localparam int SELF_SLOT = 4;
    localparam int SEL_W     = 4;

    typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;
endpackage

// File: rtl/mvr_window.sv
// Gathers the 3x3 candidate vectors around (row, col) from the flattened field.
// Slot k sits at row offset k/3-1 and column offset k%3-1. Slots that fall
// outside the field are flagged invalid and present vector 0.
module mvr_window #(
    parameter int COLS = 4,
    parameter int ROWS = 4,
    parameter int VW   = 8,
    localparam int NB  = COLS * ROWS,
    localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CLW = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic [NB*VW-1:0]                field_x,
    input  logic [NB*VW-1:0]                field_y,
    input  logic [RW-1:0]                   row,
    input  logic [CLW-1:0]                  col,
    output logic [mvr_pkg::NCAND*VW-1:0]    cand_x,
    output logic [mvr_pkg::NCAND*VW-1:0]    cand_y,
    output logic [mvr_pkg::NCAND-1:0]       cand_ok
);
    for (genvar k = 0; k < mvr_pkg::NCAND; k++) begin : g_slot
        int r, c, idx;
        // Locate slot k in the field and fetch its vector when it is in range.
        always_comb begin
            r   = int'(row) + (k / 3) - 1;
            c   = int'(col) + (k % 3) - 1;
            cand_ok[k] = (r >= 0) && (r < ROWS) && (c >= 0) && (c < COLS);
            idx = cand_ok[k] ? (r * COLS + c) : 0;
            cand_x[k*VW +: VW] = cand_ok[k] ? field_x[idx*VW +: VW] : '0;
            cand_y[k*VW +: VW] = cand_ok[k] ? field_y[idx*VW +: VW] : '0;
        end
    end
endmodule

// File: rtl/mvr_energy.sv
// Energy of one candidate: its cost plus WEIGHT times the summed L1 distance
// to every in-frame neighbour slot (all slots but the centre).
// Assumes signed VW-bit components; EW is sized so the sum cannot wrap.
module mvr_energy #(
    parameter int VW     = 8,
    parameter int CW     = 16,
    parameter int WEIGHT = 48,
    parameter int EW     = 24,
    localparam int DW    = VW + 2,
    localparam int SW    = DW + 3
) (
    input  logic [VW-1:0]                   own_x,
    input  logic [VW-1:0]                   own_y,
    input  logic [mvr_pkg::NCAND*VW-1:0]    nbr_x,
    input  logic [mvr_pkg::NCAND*VW-1:0]    nbr_y,
    input  logic [mvr_pkg::NCAND-1:0]       nbr_ok,
    input  logic [CW-1:0]                   cost,
    output logic [EW-1:0]                   energy
);
    logic signed [VW:0] dx, dy;
    logic [VW:0]        ax, ay;
    logic [SW-1:0]      dist_sum;

    // Accumulate |dx|+|dy| over the valid neighbours, then weight and add the cost.
    always_comb begin
        dist_sum = '0;
        dx = '0;
        dy = '0;
        ax = '0;
        ay = '0;
        for (int j = 0; j < mvr_pkg::NCAND; j++) begin
            if (j != mvr_pkg::SELF_SLOT && nbr_ok[j]) begin
                dx = $signed({own_x[VW-1], own_x}) - $signed({nbr_x[j*VW+VW-1], nbr_x[j*VW +: VW]});
                dy = $signed({own_y[VW-1], own_y}) - $signed({nbr_y[j*VW+VW-1], nbr_y[j*VW +: VW]});
                ax = dx[VW] ? $unsigned(-dx) : $unsigned(dx);
                ay = dy[VW] ? $unsigned(-dy) : $unsigned(dy);
                dist_sum = dist_sum + SW'(ax) + SW'(ay);
            end
        end
        energy = EW'(cost) + EW'(dist_sum) * EW'(WEIGHT);
    end
endmodule

// File: rtl/mvr_argmin.sv
// Picks the lowest-energy valid slot. The centre slot is the starting choice and
// the others are scanned in index order with a strict compare, so the centre
// keeps ties and otherwise the lowest index wins.
module mvr_argmin #(
    parameter int EW = 24
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                check_en,
    input  logic [mvr_pkg::NCAND*EW-1:0]        energy,
    input  logic [mvr_pkg::NCAND-1:0]           cand_ok,
    output logic [mvr_pkg::SEL_W-1:0]           sel
);
    // Sequential scan for the minimum with the tie rule built into the order.
    always_comb begin
        sel = mvr_pkg::SEL_W'(mvr_pkg::SELF_SLOT);
        for (int k = 0; k < mvr_pkg::NCAND; k++) begin
            if (k != mvr_pkg::SELF_SLOT && cand_ok[k] &&
                energy[k*EW +: EW] < energy[sel*EW +: EW])
                sel = mvr_pkg::SEL_W'(k);
        end
    end

    // R4: the winner is always an in-frame slot.
    p_sel_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        check_en |-> cand_ok[sel]);

    // R7: a winner tying with the centre slot must be the centre slot.
    p_tie_keeps_self_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (check_en && energy[sel*EW +: EW] == energy[mvr_pkg::SELF_SLOT*EW +: EW])
        |-> sel == mvr_pkg::SEL_W'(mvr_pkg::SELF_SLOT));

    for (genvar k = 0; k < mvr_pkg::NCAND; k++) begin : g_min_chk
        // R6: no valid slot beats the chosen one.
        p_sel_minimal_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (check_en && cand_ok[k]) |-> energy[sel*EW +: EW] <= energy[k*EW +: EW]);
    end
endmodule

// File: rtl/mvr_icm_refine.sv
// Top: holds the vector field in registers, loads it while idle, then sweeps it
// NUM_PASS times in raster order, one block per clock. The winner is written in
// place. Assumes the cost source presents cur_blk's nine costs in the same cycle.
module mvr_icm_refine #(
    parameter int COLS     = 4,
    parameter int ROWS     = 4,
    parameter int VW       = 8,
    parameter int CW       = 16,
    parameter int WEIGHT   = 48,
    parameter int NUM_PASS = 3,
    localparam int NB      = COLS * ROWS,
    localparam int IW      = (NB > 1) ? $clog2(NB) : 1,
    localparam int RW      = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CLW     = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int PW      = (NUM_PASS > 1) ? $clog2(NUM_PASS) : 1,
    localparam int WBITS   = $clog2(WEIGHT + 1),
    localparam int PENW    = VW + 5 + WBITS,
    localparam int EW      = ((CW > PENW) ? CW : PENW) + 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ld_en,
    input  logic [IW-1:0]                  ld_idx,
    input  logic [VW-1:0]                  ld_mvx,
    input  logic [VW-1:0]                  ld_mvy,
    input  logic                           start,
    input  logic [mvr_pkg::NCAND*CW-1:0]   cost_bus,
    output logic [IW-1:0]                  cur_blk,
    output logic                           busy,
    output logic                           done,
    output logic                           upd_valid,
    output logic [IW-1:0]                  upd_idx,
    output logic [mvr_pkg::SEL_W-1:0]      upd_sel,
    output logic [VW-1:0]                  upd_mvx,
    output logic [VW-1:0]                  upd_mvy,
    input  logic [IW-1:0]                  rd_idx,
    output logic [VW-1:0]                  rd_mvx,
    output logic [VW-1:0]                  rd_mvy
);
    import mvr_pkg::*;

    seq_state_e               state;
    logic [IW-1:0]            cur_q;
    logic [RW-1:0]            row_q;
    logic [CLW-1:0]           col_q;
    logic [PW-1:0]            pass_q;
    logic [VW-1:0]            fx [NB];
    logic [VW-1:0]            fy [NB];
    logic [NB*VW-1:0]         flat_x, flat_y;
    logic [NCAND*VW-1:0]      cand_x, cand_y;
    logic [NCAND-1:0]         cand_ok;
    logic [NCAND*EW-1:0]      energy;
    logic [SEL_W-1:0]         sel;
    logic                     run;

    assign run     = (state == ST_RUN);
    assign busy    = run;
    assign cur_blk = cur_q;
    assign rd_mvx  = fx[rd_idx];
    assign rd_mvy  = fy[rd_idx];

    // Flatten the field registers for the window gatherer.
    always_comb begin
        for (int i = 0; i < NB; i++) begin
            flat_x[i*VW +: VW] = fx[i];
            flat_y[i*VW +: VW] = fy[i];
        end
    end

    mvr_window #(.COLS(COLS), .ROWS(ROWS), .VW(VW)) u_window (
        .field_x (flat_x),
        .field_y (flat_y),
        .row     (row_q),
        .col     (col_q),
        .cand_x  (cand_x),
        .cand_y  (cand_y),
        .cand_ok (cand_ok)
    );

    for (genvar k = 0; k < NCAND; k++) begin : g_energy
        mvr_energy #(.VW(VW), .CW(CW), .WEIGHT(WEIGHT), .EW(EW)) u_energy (
            .own_x  (cand_x[k*VW +: VW]),
            .own_y  (cand_y[k*VW +: VW]),
            .nbr_x  (cand_x),
            .nbr_y  (cand_y),
            .nbr_ok (cand_ok),
            .cost   (cost_bus[k*CW +: CW]),
            .energy (energy[k*EW +: EW])
        );
    end

    mvr_argmin #(.EW(EW)) u_argmin (
        .clk      (clk),
        .rst_n    (rst_n),
        .check_en (run),
        .energy   (energy),
        .cand_ok  (cand_ok),
        .sel      (sel)
    );

    // Sequencer: idle loading, raster/pass stepping and in-place write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_q     <= '0;
            row_q     <= '0;
            col_q     <= '0;
            pass_q    <= '0;
            done      <= 1'b0;
            upd_valid <= 1'b0;
            upd_idx   <= '0;
            upd_sel   <= '0;
            upd_mvx   <= '0;
            upd_mvy   <= '0;
            for (int i = 0; i < NB; i++) begin
                fx[i] <= '0;
                fy[i] <= '0;
            end
        end else begin
            done      <= 1'b0;
            upd_valid <= 1'b0;
            if (state == ST_IDLE) begin
                if (ld_en) begin
                    fx[ld_idx] <= ld_mvx;
                    fy[ld_idx] <= ld_mvy;
                end
                if (start) begin
                    state  <= ST_RUN;
                    cur_q  <= '0;
                    row_q  <= '0;
                    col_q  <= '0;
                    pass_q <= '0;
                end
            end else begin
                fx[cur_q] <= cand_x[sel*VW +: VW];
                fy[cur_q] <= cand_y[sel*VW +: VW];
                upd_valid <= 1'b1;
                upd_idx   <= cur_q;
                upd_sel   <= sel;
                upd_mvx   <= cand_x[sel*VW +: VW];
                upd_mvy   <= cand_y[sel*VW +: VW];
                if (int'(col_q) == COLS - 1) begin
                    col_q <= '0;
                    if (int'(row_q) == ROWS - 1) begin
                        row_q <= '0;
                        cur_q <= '0;
                        if (int'(pass_q) == NUM_PASS - 1) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            pass_q <= pass_q + 1'b1;
                        end
                    end else begin
                        row_q <= row_q + 1'b1;
                        cur_q <= cur_q + 1'b1;
                    end
                end else begin
                    col_q <= col_q + 1'b1;
                    cur_q <= cur_q + 1'b1;
                end
            end
        end
    end

    // R3: done never overlaps a running sweep.
    p_done_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R3: an update only follows a cycle spent running, and names that cycle's block.
    p_update_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> ($past(run) && upd_idx == $past(cur_q)));

    // R3: consecutive running cycles step through the field in raster order.
    p_raster_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |->
        ((cur_q == IW'($past(cur_q) + 1'b1)) || (cur_q == '0 && int'($past(cur_q)) == NB - 1)));

    // R8: the reported vector is what now sits in the field.
    p_in_place_r8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (fx[upd_idx] == upd_mvx && fy[upd_idx] == upd_mvy));

    // R10: while running, the field entry at ld_idx moves only if it is the block being refined.
    p_load_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ld_en && ld_idx != cur_q) |=> (fx[$past(ld_idx)] == $past(fx[ld_idx])));
endmodule

// File: tb/sim_mvr_icm_refine.sv
// Self-checking bench: a behavioural model of the field is advanced alongside
// the design and compared on every clock of a run.
module sim_mvr_icm_refine;
    localparam int CLK_PERIOD = 10;
    localparam int COLS = 4, ROWS = 4, NB = 16, VW = 8, CW = 16, NP = 3, WT = 48;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ld_en = 1'b0;
    logic [3:0]       ld_idx = '0;
    logic [VW-1:0]    ld_mvx = '0, ld_mvy = '0;
    logic             start = 1'b0;
    logic [9*CW-1:0]  cost_bus = '0;
    logic [3:0]       cur_blk;
    logic             busy, done, upd_valid;
    logic [3:0]       upd_idx, upd_sel;
    logic [VW-1:0]    upd_mvx, upd_mvy;
    logic [3:0]       rd_idx = '0;
    logic [VW-1:0]    rd_mvx, rd_mvy;

    int total = 0, bad = 0;
    int mx [NB];
    int my [NB];
    int cst [9];
    int exp_sel, exp_x, exp_y;

    always #(CLK_PERIOD/2) clk = ~clk;

    mvr_icm_refine u0 (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_mvx(ld_mvx),
        .ld_mvy(ld_mvy), .start(start), .cost_bus(cost_bus), .cur_blk(cur_blk),
        .busy(busy), .done(done), .upd_valid(upd_valid), .upd_idx(upd_idx),
        .upd_sel(upd_sel), .upd_mvx(upd_mvx), .upd_mvy(upd_mvy), .rd_idx(rd_idx),
        .rd_mvx(rd_mvx), .rd_mvy(rd_mvy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    function automatic int hsh(input int a);
        int unsigned v;
        v = int'(a) * 1103515245 + 12345;
        return int'((v >> 8) & 32'h00FF_FFFF);
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Cost per slot for a given pattern, block and pass.
    function automatic int cost_of(input int mode, input int blk, input int p, input int k);
        case (mode)
            1: return hsh(blk * 97 + p * 13 + k * 7) % 3000;
            2: return 65535 - (hsh(blk * 31 + p * 5 + k) % 50);
            3: return (k == 4) ? 100 : 0;
            default: return 0;
        endcase
    endfunction

    // Reference choice for block b from the model field and cst[] (R4-R7).
    task automatic model_pick(input int b);
        int r, c, cxv[9], cyv[9], e[9];
        bit okv[9];
        r = b / COLS; c = b % COLS;
        for (int k = 0; k < 9; k++) begin
            int rr, cc;
            rr = r + k / 3 - 1; cc = c + k % 3 - 1;
            okv[k] = (rr >= 0 && rr < ROWS && cc >= 0 && cc < COLS);
            cxv[k] = okv[k] ? mx[rr*COLS+cc] : 0;
            cyv[k] = okv[k] ? my[rr*COLS+cc] : 0;
        end
        for (int k = 0; k < 9; k++) begin
            int s;
            s = 0;
            for (int j = 0; j < 9; j++)
                if (j != 4 && okv[j]) s += iabs(cxv[k] - cxv[j]) + iabs(cyv[k] - cyv[j]);
            e[k] = cst[k] + WT * s;
        end
        exp_sel = 4;
        for (int k = 0; k < 9; k++)
            if (k != 4 && okv[k] && e[k] < e[exp_sel]) exp_sel = k;
        exp_x = cxv[exp_sel]; exp_y = cyv[exp_sel];
    endtask

    task automatic load_field(input int mode);
        for (int i = 0; i < NB; i++) begin
            int vx, vy;
            case (mode)
                0: begin vx = 0; vy = 0; end
                1: begin vx = (hsh(i * 11 + 3) % 81) - 40; vy = (hsh(i * 17 + 5) % 81) - 40; end
                2: begin vx = (((i / COLS) + i) % 2 == 0) ? 127 : -128;
                         vy = (((i / COLS) + i) % 2 == 0) ? -128 : 127; end
                default: begin vx = (i == 5) ? 90 : 3; vy = (i == 10) ? -77 : -2; end
            endcase
            @(negedge clk);
            ld_en = 1'b1; ld_idx = 4'(i); ld_mvx = VW'(vx); ld_mvy = VW'(vy);
            mx[i] = vx; my[i] = vy;
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic readback(input string req);
        for (int i = 0; i < NB; i++) begin
            rd_idx = 4'(i);
            #1;
            chk(int'($signed(rd_mvx)) == mx[i], {req, " rd_mvx"}, int'($signed(rd_mvx)), mx[i]);
            chk(int'($signed(rd_mvy)) == my[i], {req, " rd_mvy"}, int'($signed(rd_mvy)), my[i]);
        end
    endtask

    // One full run; disturb injects a load and a start mid-run (R10).
    task automatic run(input int mode, input bit disturb, input string req);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R3 busy after start", int'(busy), 1);
        for (int p = 0; p < NP; p++) begin
            for (int b = 0; b < NB; b++) begin
                chk(int'(cur_blk) == b && busy, "R3 raster cur_blk", int'(cur_blk), b);
                for (int k = 0; k < 9; k++) begin
                    cst[k] = cost_of(mode, b, p, k);
                    cost_bus[k*CW +: CW] = CW'(cst[k]);   // R11 slot layout
                end
                if (disturb && p == 1 && b == 5) begin
                    ld_en = 1'b1; ld_idx = 4'd2; ld_mvx = 8'd99; ld_mvy = 8'd99; start = 1'b1;
                end
                model_pick(b);
                @(negedge clk);
                ld_en = 1'b0; start = 1'b0;
                chk(upd_valid && int'(upd_idx) == b, {req, " R6 upd_idx"}, int'(upd_idx), b);
                chk(int'(upd_sel) == exp_sel, {req, " R7 upd_sel"}, int'(upd_sel), exp_sel);
                chk(int'($signed(upd_mvx)) == exp_x, {req, " R5 upd_mvx"}, int'($signed(upd_mvx)), exp_x);
                chk(int'($signed(upd_mvy)) == exp_y, {req, " R5 upd_mvy"}, int'($signed(upd_mvy)), exp_y);
                mx[b] = exp_x; my[b] = exp_y;   // R8 in-place model update
            end
        end
        chk(done && !busy, "R3 done pulse", int'(done), 1);
        @(negedge clk);
        chk(!done && !upd_valid, "R3 done one cycle", int'(done), 0);
        readback({req, " R8 final field"});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NB; i++) begin mx[i] = 0; my[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!busy && !done && !upd_valid, "R1 reset outputs", int'(busy), 0);
        readback("R1 reset field");
        load_field(1);
        readback("R2 load");
        run(0, 1'b0, "R5 zero cost");
        load_field(1);
        run(1, 1'b0, "R6 random cost");
        load_field(0);
        run(3, 1'b0, "R7 lowest index tie");
        run(0, 1'b0, "R7 self tie");
        load_field(2);
        run(2, 1'b0, "R9 extremes");
        load_field(3);
        run(1, 1'b1, "R10 busy ignore");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule